// File: doc/BRIEF.md
# Hybrid Branch Direction Predictor

This block supplies the next fetch address for a pipelined processor's fetch stage. It keeps a small direct-mapped buffer of recently resolved conditional branches. The buffer is indexed by low program-counter bits and tagged with the remaining upper bits. Each entry holds the branch destination and a two-bit saturating direction counter. On a lookup hit, the block predicts from that counter and, when the prediction is taken, returns the stored destination.

When the lookup misses, the block uses a static rule instead. Decode supplies the branch offset, already sign-extended. A negative offset means a backward branch, which is predicted taken toward PC+4+offset. Any other offset is predicted not taken, toward PC+4.

Later in the pipeline, the processor reports each branch's real outcome and destination on a resolve port. That report either trains the matching entry or allocates a new entry over whatever occupied the slot.

Top module: `branch_dir_predictor`

## Requirements
- R1: After a synchronous reset, every buffer entry is invalid, so the next lookup reports `pred_hit` = 0.
- R2: On a miss with a negative offset (bit PC_W-1 set), `pred_taken` = 1 and `pred_next_pc` = lookup_pc + 4 + offset.
- R3: On a miss with a zero or positive offset, `pred_taken` = 0 and `pred_next_pc` = lookup_pc + 4.
- R4: On a hit, `pred_taken` follows the entry's counter. The counter encoding is 0 = strong not-taken, 1 = weak not-taken, 2 = weak taken, 3 = strong taken; codes 2 and 3 predict taken, whatever the offset's sign.
- R5: On a hit predicting taken, `pred_next_pc` is the stored destination. On a hit predicting not taken, it is lookup_pc + 4.
- R6: A resolve that hits moves the counter one step up on a taken outcome and one step down on a not-taken outcome. The counter saturates at 3 and at 0.
- R7: A resolve that misses allocates the entry. It sets the valid bit, stores the tag and destination, and seeds the counter with 2 if the outcome was taken, otherwise with 1.
- R8: A branch whose tag differs from the resident entry at the same index misses. Resolving that branch replaces the resident entry, after which the old branch misses.
- R9: A lookup and a resolve to the same entry in the same cycle return the state from before the update; the update shows from the next cycle.
- R10: For a loop branch that has settled, each pass through the loop costs exactly one misprediction, at the exit. A one-bit last-outcome scheme would cost two per pass.
- R11: The index is PC[IDX_W+1:2] and the tag is PC[PC_W-1:IDX_W+2]. PC bits [1:0] have no effect on lookup or resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_pc | input | PC_W | Fetch address of the branch being predicted |
| lookup_offset | input | PC_W | Sign-extended branch offset from decode |
| pred_hit | output | 1 | Lookup found a valid entry with a matching tag |
| pred_taken | output | 1 | Predicted direction |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| resolve_valid | input | 1 | A resolved branch is reported this cycle |
| resolve_pc | input | PC_W | Address of the resolved branch |
| resolve_taken | input | 1 | Actual outcome of the resolved branch |
| resolve_target | input | PC_W | Actual destination of the resolved branch |

## Verification
The assertions check the per-cycle rules on every cycle:
- the static fallback on a miss, for both signs of the offset;
- PC+4 on a hit that predicts not taken;
- a one-step or saturating counter move on each resolve hit;
- a valid slot after each write;
- no hit just after reset.

Some behaviours need a sequence of cycles, so only the bench's scenarios can show them:
- a counter walking through all four codes;
- a tag conflict evicting a resident entry;
- lookup results that do not change during a same-cycle update;
- low PC bits having no effect;
- the loop pattern, where the two-bit counter pays once per pass and a one-bit model pays twice.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_SNT = 2'd0;
  localparam ctr_t CTR_WNT = 2'd1;
  localparam ctr_t CTR_WT  = 2'd2;
  localparam ctr_t CTR_ST  = 2'd3;

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/bp_ctr_step.sv
module bp_ctr_step
  import bp_pkg::*;
(
  input  logic hit,
  input  ctr_t cur,
  input  logic taken,
  output ctr_t nxt
);
  always_comb begin
    if (!hit)
      nxt = taken ? CTR_WT : CTR_WNT;
    else if (taken)
      nxt = (cur == CTR_ST) ? CTR_ST : cur + 2'd1;
    else
      nxt = (cur == CTR_SNT) ? CTR_SNT : cur - 2'd1;
  end
endmodule

// File: rtl/bp_static_fallback.sv
module bp_static_fallback #(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] offset,
  output logic            taken,
  output logic [PC_W-1:0] seq_pc,
  output logic [PC_W-1:0] next_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  always_comb begin
    seq_pc  = pc + STEP;
    taken   = offset[PC_W-1];
    next_pc = taken ? seq_pc + offset : seq_pc;
  end
endmodule

// File: rtl/bp_entry_store.sv
module bp_entry_store
  import bp_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_vld,
  output logic [TAG_W-1:0] a_tag,
  output logic [PC_W-1:0]  a_tgt,
  output ctr_t             a_ctr,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_vld,
  output logic [TAG_W-1:0] b_tag,
  output ctr_t             b_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  ctr_t             wr_ctr
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [PC_W-1:0]  tgt_mem [DEPTH];
  ctr_t             ctr_mem [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_tgt;
      ctr_mem[wr_idx] <= wr_ctr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      vld_q <= '0;
    else if (wr_en)
      vld_q[wr_idx] <= 1'b1;
  end

  assign a_vld = vld_q[a_idx];
  assign a_tag = tag_mem[a_idx];
  assign a_tgt = tgt_mem[a_idx];
  assign a_ctr = ctr_mem[a_idx];
  assign b_vld = vld_q[b_idx];
  assign b_tag = tag_mem[b_idx];
  assign b_ctr = ctr_mem[b_idx];

  // R7
  alloc_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lookup_pc,
  input  logic [PC_W-1:0] lookup_offset,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            resolve_valid,
  input  logic [PC_W-1:0] resolve_pc,
  input  logic            resolve_taken,
  input  logic [PC_W-1:0] resolve_target
);
  localparam int LO    = 2;
  localparam int TAG_W = PC_W - IDX_W - LO;

  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  logic             lk_vld, rs_vld;
  logic [TAG_W-1:0] lk_stag, rs_stag;
  logic [PC_W-1:0]  lk_tgt;
  ctr_t             lk_ctr, rs_ctr, ctr_nxt;
  logic             rs_hit;
  logic             st_taken;
  logic [PC_W-1:0]  st_seq, st_next;
  logic             unused_lowbits;

  assign lk_idx = lookup_pc[IDX_W+LO-1:LO];
  assign lk_tag = lookup_pc[PC_W-1:IDX_W+LO];
  assign rs_idx = resolve_pc[IDX_W+LO-1:LO];
  assign rs_tag = resolve_pc[PC_W-1:IDX_W+LO];
  assign unused_lowbits = ^{lookup_pc[LO-1:0], resolve_pc[LO-1:0]};

  bp_entry_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .a_idx  (lk_idx),
    .a_vld  (lk_vld),
    .a_tag  (lk_stag),
    .a_tgt  (lk_tgt),
    .a_ctr  (lk_ctr),
    .b_idx  (rs_idx),
    .b_vld  (rs_vld),
    .b_tag  (rs_stag),
    .b_ctr  (rs_ctr),
    .wr_en  (resolve_valid),
    .wr_idx (rs_idx),
    .wr_tag (rs_tag),
    .wr_tgt (resolve_target),
    .wr_ctr (ctr_nxt)
  );

  assign rs_hit = rs_vld && (rs_stag == rs_tag);

  bp_ctr_step u_step (
    .hit   (rs_hit),
    .cur   (rs_ctr),
    .taken (resolve_taken),
    .nxt   (ctr_nxt)
  );

  bp_static_fallback #(.PC_W(PC_W)) u_static (
    .pc      (lookup_pc),
    .offset  (lookup_offset),
    .taken   (st_taken),
    .seq_pc  (st_seq),
    .next_pc (st_next)
  );

  always_comb begin
    pred_hit = lk_vld && (lk_stag == lk_tag);
    if (pred_hit) begin
      pred_taken   = ctr_says_taken(lk_ctr);
      pred_next_pc = pred_taken ? lk_tgt : st_seq;
    end else begin
      pred_taken   = st_taken;
      pred_next_pc = st_next;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pred_hit);
  // R2
  back_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (!pred_hit && lookup_offset[PC_W-1]) |->
      (pred_taken && pred_next_pc == lookup_pc + PC_W'(4) + lookup_offset));
  // R3
  fwd_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (!pred_hit && !lookup_offset[PC_W-1]) |->
      (!pred_taken && pred_next_pc == lookup_pc + PC_W'(4)));
  // R5
  hit_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_hit && !pred_taken) |-> pred_next_pc == lookup_pc + PC_W'(4));
  // R6
  ctr_up_chk: assert property (@(posedge clk) disable iff (rst)
    (resolve_valid && rs_hit && resolve_taken) |->
      ((ctr_nxt == rs_ctr + 2'd1) || (rs_ctr == CTR_ST && ctr_nxt == CTR_ST)));
  // R6
  ctr_down_chk: assert property (@(posedge clk) disable iff (rst)
    (resolve_valid && rs_hit && !resolve_taken) |->
      ((ctr_nxt == rs_ctr - 2'd1) || (rs_ctr == CTR_SNT && ctr_nxt == CTR_SNT)));
endmodule

// File: tb/branch_dir_predictor_test.sv
`timescale 1ns/1ps
module branch_dir_predictor_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lookup_pc = '0, lookup_offset = '0;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_next_pc;
  logic        resolve_valid = 1'b0, resolve_taken = 1'b0;
  logic [31:0] resolve_pc = '0, resolve_target = '0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  branch_dir_predictor uut (
    .clk(clk), .rst(rst),
    .lookup_pc(lookup_pc), .lookup_offset(lookup_offset),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .resolve_valid(resolve_valid), .resolve_pc(resolve_pc),
    .resolve_taken(resolve_taken), .resolve_target(resolve_target)
  );

  typedef struct packed {
    logic        rv;
    logic [31:0] rpc;
    logic        rt;
    logic [31:0] rtgt;
    logic [31:0] lpc;
    logic [31:0] loff;
    logic        ehit;
    logic        etk;
    logic [31:0] enext;
  } vec_t;

  localparam int NV = 15;
  // A = 0x1010 and B = 0x2010 share index 4 with different tags.
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0,    1'b0, 32'h0,    32'h1010, 32'hFFFFFFF0, 1'b0, 1'b1, 32'h1004}, // R1 R2
    '{1'b1, 32'h1010, 1'b1, 32'h1000, 32'h1010, 32'h20,       1'b0, 1'b0, 32'h1014}, // R3 R9 alloc WT
    '{1'b1, 32'h1010, 1'b1, 32'h1000, 32'h1010, 32'h20,       1'b1, 1'b1, 32'h1000}, // R7 R4 R5 -> ST
    '{1'b1, 32'h1010, 1'b1, 32'h1000, 32'h1010, 32'h20,       1'b1, 1'b1, 32'h1000}, // R6 sat ST
    '{1'b1, 32'h1010, 1'b0, 32'h1000, 32'h1010, 32'h20,       1'b1, 1'b1, 32'h1000}, // R6 -> WT
    '{1'b1, 32'h1010, 1'b0, 32'h1000, 32'h1010, 32'h20,       1'b1, 1'b1, 32'h1000}, // R6 -> WNT
    '{1'b1, 32'h1010, 1'b0, 32'h1000, 32'h1010, 32'hFFFFFFF0, 1'b1, 1'b0, 32'h1014}, // R4 R5 -> SNT
    '{1'b1, 32'h1010, 1'b0, 32'h1000, 32'h1010, 32'h20,       1'b1, 1'b0, 32'h1014}, // R6 sat SNT
    '{1'b1, 32'h1010, 1'b1, 32'h1000, 32'h1010, 32'h20,       1'b1, 1'b0, 32'h1014}, // R6 -> WNT
    '{1'b1, 32'h1010, 1'b1, 32'h1000, 32'h1010, 32'h20,       1'b1, 1'b0, 32'h1014}, // R9 -> WT
    '{1'b0, 32'h0,    1'b0, 32'h0,    32'h1010, 32'h20,       1'b1, 1'b1, 32'h1000}, // R6 up
    '{1'b1, 32'h2010, 1'b0, 32'h2100, 32'h2010, 32'h0,        1'b0, 1'b0, 32'h2014}, // R8 R3 alloc WNT
    '{1'b0, 32'h0,    1'b0, 32'h0,    32'h1010, 32'hFFFFFFF0, 1'b0, 1'b1, 32'h1004}, // R8 evicted
    '{1'b1, 32'h2013, 1'b1, 32'h2100, 32'h2012, 32'h0,        1'b1, 1'b0, 32'h2016}, // R11 -> WT
    '{1'b0, 32'h0,    1'b0, 32'h0,    32'h2010, 32'h0,        1'b1, 1'b1, 32'h2100}  // R11 R5
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive on the falling edge, sample 1 ns later; the update lands at the next rising edge.
  task automatic step(input logic rv, input logic [31:0] rpc, input logic rt,
                      input logic [31:0] rtgt, input logic [31:0] lpc,
                      input logic [31:0] loff);
    @(negedge clk);
    resolve_valid = rv; resolve_pc = rpc; resolve_taken = rt; resolve_target = rtgt;
    lookup_pc = lpc; lookup_offset = loff;
    #1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int dut_miss, one_bit_miss;
    logic one_bit_state, one_bit_valid, actual;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(1'b0, 32'h0, 1'b0, 32'h0, 32'h40, 32'h0);
    chk("R1", "hit after reset", 32'(pred_hit), 32'd0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].rv, VEC[i].rpc, VEC[i].rt, VEC[i].rtgt, VEC[i].lpc, VEC[i].loff);
      chk("R4/R8", $sformatf("vec%0d hit", i), 32'(pred_hit), 32'(VEC[i].ehit));
      chk("R2/R3/R4", $sformatf("vec%0d taken", i), 32'(pred_taken), 32'(VEC[i].etk));
      chk("R5/R6/R7", $sformatf("vec%0d next", i), pred_next_pc, VEC[i].enext);
    end

    // R10: loop branch at 0x3020 jumping back to 0x3004; four taken then one exit, five passes.
    dut_miss = 0; one_bit_miss = 0; one_bit_valid = 1'b0; one_bit_state = 1'b0;
    for (int pass = 0; pass < 5; pass++) begin
      for (int it = 0; it < 5; it++) begin
        actual = (it < 4);
        step(1'b1, 32'h3020, actual, 32'h3004, 32'h3020, 32'hFFFFFFE0);
        if (pass >= 2) begin
          if (pred_taken !== actual) dut_miss++;
          if ((one_bit_valid ? one_bit_state : 1'b1) != actual) one_bit_miss++;
        end
        one_bit_state = actual; one_bit_valid = 1'b1;
      end
    end
    chk("R10", "2-bit mispredicts over 3 passes", 32'(dut_miss), 32'd3);
    chk("R10", "1-bit model mispredicts over 3 passes", 32'(one_bit_miss), 32'd6);

    // R9: same-cycle update to a fresh slot is not visible to the lookup.
    step(1'b1, 32'h4000, 1'b1, 32'h4800, 32'h4000, 32'h8);
    chk("R9", "hit during alloc", 32'(pred_hit), 32'd0);
    step(1'b0, 32'h0, 1'b0, 32'h0, 32'h4000, 32'h8);
    chk("R9", "hit after alloc", 32'(pred_hit), 32'd1);
    chk("R7", "target after alloc", pred_next_pc, 32'h4800);

    // R1: a mid-run reset invalidates everything.
    @(negedge clk); rst = 1'b1; resolve_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    step(1'b0, 32'h0, 1'b0, 32'h0, 32'h4000, 32'h8);
    chk("R1", "hit after second reset", 32'(pred_hit), 32'd0);
    chk("R3", "next after second reset", pred_next_pc, 32'h4004);

    done = 1'b1;
    summary();
  end
endmodule